// File: doc/BRIEF.md
# Mailbox Channel Window Register Bank

This block is the receiving side of an inter-processor mailbox. It holds a parameterised number of 32-bit channel windows. Each window keeps a status word, which the remote processor raises bit by bit through a set-pulse input and which local software can also set or clear through separate write-one-to-set and write-one-to-clear addresses. Each window also keeps a mask word, with its own set and clear addresses. Software reads a raw view and a masked view of every window.

A window with any unmasked status bit is pending. The pending flags of all windows are packed into a combined status vector, one bit per window across four 32-bit words. A lowest-index lookup reports the first pending window. A single interrupt line reflects the combined vector, gated by a global enable bit. A read-only word reports how many windows are built.

Access is through a simple request bus: a request with a word address, a write flag and write data is taken in one cycle. Read data comes back one cycle later with a valid strobe.

Top module: `cw_mbox_bank`

## Requirements
- R1: After reset every status bit is 0, every mask bit is 1, the global enable is 0 and the interrupt output is low.
- R2: Window registers sit at address {0, window[6:0], offset[2:0]}. Writing offset 1 sets the status bits written as 1. A pulse on the remote set input bit w*32+b sets status bit b of window w. Offset 0 reads the raw status.
- R3: Writing offset 2 clears the status bits written as 1 and leaves the others unchanged.
- R4: Writing offset 5 sets mask bits and writing offset 6 clears mask bits, for the bits written as 1. Offset 4 reads the mask.
- R5: Offset 3 reads the status ANDed with the inverted mask.
- R6: Global registers sit at address {1, 7'd0, offset[2:0]}. Offsets 2 to 5 read combined status words 0 to 3. Bit n%32 of word n/32 is 1 exactly when window n has an unmasked status bit set.
- R7: The interrupt output is high exactly when the enable bit (global offset 1, bit 0, read/write) is 1 and some window is pending. It follows a change of state one clock later.
- R8: When a status bit is cleared and set in the same cycle, the clear wins.
- R9: Writes to a window index at or above the built count, to read-only offsets, or to the configuration word change nothing. Reads of such window indices, of write-only offsets and of unused addresses return 0.
- R10: Global offset 0 reads the number of windows built.
- R11: Global offset 6 reads bit 31 = 1 when any window is pending, with bits 6:0 holding the lowest pending window index. Otherwise it reads 0.
- R12: Every read request returns its data with the valid strobe exactly one cycle later. The strobe stays low for writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 11 | Word address |
| req_wdata | input | 32 | Write data |
| remote_set_i | input | NUM_WIN*32 | Set pulses from the remote side, one per status bit |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 32 | Read data |
| irq_o | output | 1 | Combined mailbox interrupt |

## Verification
A write or a remote set pulse sampled at one rising edge changes window state at that edge. A read issued at the next edge therefore sees the new value, and its data appears after that edge. The interrupt register sees the change one edge later than the state does. The driver presents every request at a falling edge and pushes the expected word into a queue. The monitor pops and compares that word at the falling edge on which the valid strobe appears. Interrupt checks are made one full cycle after the write that causes them, at a falling edge.

// File: rtl/cw_pkg.sv
package cw_pkg;
  localparam int unsigned DW        = 32;
  localparam int unsigned IDX_W     = 7;
  localparam int unsigned MAX_SLOTS = 1 << IDX_W;
  localparam int unsigned CMB_WORDS = MAX_SLOTS / DW;
  localparam int unsigned OFS_W     = 3;
  localparam int unsigned ADDR_W    = 1 + IDX_W + OFS_W;

  typedef enum logic [OFS_W-1:0] {
    WR_RAW    = 3'd0,
    WR_SET    = 3'd1,
    WR_CLR    = 3'd2,
    WR_MASKED = 3'd3,
    WR_MASK   = 3'd4,
    WR_MSET   = 3'd5,
    WR_MCLR   = 3'd6,
    WR_RSVD   = 3'd7
  } win_ofs_e;

  typedef enum logic [OFS_W-1:0] {
    GR_CFG   = 3'd0,
    GR_IEN   = 3'd1,
    GR_CMB0  = 3'd2,
    GR_CMB1  = 3'd3,
    GR_CMB2  = 3'd4,
    GR_CMB3  = 3'd5,
    GR_FIRST = 3'd6,
    GR_RSVD  = 3'd7
  } glob_ofs_e;
endpackage

// File: rtl/cw_window.sv
module cw_window
  import cw_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] set_bits,
  input  logic [DW-1:0] clr_bits,
  input  logic [DW-1:0] mset_bits,
  input  logic [DW-1:0] mclr_bits,
  output logic [DW-1:0] stat_o,
  output logic [DW-1:0] mask_o
);
  logic [DW-1:0] stat_q, mask_q;

  // the clear term is applied last, so it overrides a set in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      mask_q <= '1;
    end else begin
      stat_q <= (stat_q | set_bits) & ~clr_bits;
      mask_q <= (mask_q | mset_bits) & ~mclr_bits;
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/cw_pending_summary.sv
module cw_pending_summary
  import cw_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [MAX_SLOTS-1:0] pend,
  input  logic                 ien,
  output logic [MAX_SLOTS-1:0] cmb_o,
  output logic                 first_vld_o,
  output logic [IDX_W-1:0]     first_idx_o,
  output logic                 irq_o
);
  logic irq_q;

  always_comb begin
    first_vld_o = 1'b0;
    first_idx_o = '0;
    for (int i = MAX_SLOTS - 1; i >= 0; i--) begin
      if (pend[i]) begin
        first_vld_o = 1'b1;
        first_idx_o = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= ien & (|pend);
  end

  assign cmb_o = pend;
  assign irq_o = irq_q;
endmodule

// File: rtl/cw_mbox_bank.sv
module cw_mbox_bank
  import cw_pkg::*;
#(
  parameter int unsigned NUM_WIN = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DW-1:0]         req_wdata,
  input  logic [NUM_WIN*DW-1:0] remote_set_i,
  output logic                  rd_valid_o,
  output logic [DW-1:0]         rd_data_o,
  output logic                  irq_o
);
  localparam int unsigned FLAT_W = NUM_WIN * DW;

  logic                 glob_sel;
  logic [IDX_W-1:0]     win_idx;
  logic [OFS_W-1:0]     ofs;
  logic                 wr_en, rd_en;
  logic [FLAT_W-1:0]    stat_flat, mask_flat;
  logic [DW-1:0]        stat_pad [MAX_SLOTS];
  logic [DW-1:0]        mask_pad [MAX_SLOTS];
  logic [MAX_SLOTS-1:0] pend;
  logic [MAX_SLOTS-1:0] cmb;
  logic                 first_vld;
  logic [IDX_W-1:0]     first_idx;
  logic                 ien_q;
  logic                 rd_valid_q;
  logic [DW-1:0]        rd_data_q, rd_mux;

  assign glob_sel = req_addr[ADDR_W-1];
  assign win_idx  = req_addr[OFS_W +: IDX_W];
  assign ofs      = req_addr[OFS_W-1:0];
  assign wr_en    = req_valid & req_write;
  assign rd_en    = req_valid & ~req_write;

  for (genvar w = 0; w < MAX_SLOTS; w++) begin : g_slot
    if (w < NUM_WIN) begin : g_win
      logic          hit;
      logic [DW-1:0] s_o, m_o;
      assign hit = wr_en & ~glob_sel & (win_idx == IDX_W'(w));
      cw_window u_win (
        .clk       (clk),
        .rst       (rst),
        .set_bits  ((hit && ofs == WR_SET  ? req_wdata : '0) | remote_set_i[w*DW +: DW]),
        .clr_bits  (hit && ofs == WR_CLR  ? req_wdata : '0),
        .mset_bits (hit && ofs == WR_MSET ? req_wdata : '0),
        .mclr_bits (hit && ofs == WR_MCLR ? req_wdata : '0),
        .stat_o    (s_o),
        .mask_o    (m_o)
      );
      assign stat_flat[w*DW +: DW] = s_o;
      assign mask_flat[w*DW +: DW] = m_o;
      assign stat_pad[w] = s_o;
      assign mask_pad[w] = m_o;
      assign pend[w]     = |(s_o & ~m_o);
    end else begin : g_empty
      assign stat_pad[w] = '0;
      assign mask_pad[w] = '0;
      assign pend[w]     = 1'b0;
    end
  end

  cw_pending_summary u_sum (
    .clk         (clk),
    .rst         (rst),
    .pend        (pend),
    .ien         (ien_q),
    .cmb_o       (cmb),
    .first_vld_o (first_vld),
    .first_idx_o (first_idx),
    .irq_o       (irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) ien_q <= 1'b0;
    else if (wr_en && glob_sel && win_idx == '0 && ofs == GR_IEN) ien_q <= req_wdata[0];
  end

  always_comb begin
    rd_mux = '0;
    if (!glob_sel) begin
      unique case (ofs)
        WR_RAW:    rd_mux = stat_pad[win_idx];
        WR_MASKED: rd_mux = stat_pad[win_idx] & ~mask_pad[win_idx];
        WR_MASK:   rd_mux = mask_pad[win_idx];
        default:   rd_mux = '0;
      endcase
    end else if (win_idx == '0) begin
      unique case (ofs)
        GR_CFG:   rd_mux = DW'(NUM_WIN);
        GR_IEN:   rd_mux = {{(DW-1){1'b0}}, ien_q};
        GR_CMB0:  rd_mux = cmb[0*DW +: DW];
        GR_CMB1:  rd_mux = cmb[1*DW +: DW];
        GR_CMB2:  rd_mux = cmb[2*DW +: DW];
        GR_CMB3:  rd_mux = cmb[3*DW +: DW];
        GR_FIRST: rd_mux = {first_vld, {(DW-1-IDX_W){1'b0}}, first_idx};
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_en;
      rd_data_q  <= rd_en ? rd_mux : '0;
    end
  end

  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_data_q;
endmodule

// File: rtl/cw_mbox_bank_chk.sv
module cw_mbox_bank_chk
  import cw_pkg::*;
#(
  parameter int unsigned NUM_WIN = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  req_valid,
  input logic                  req_write,
  input logic [ADDR_W-1:0]     req_addr,
  input logic [DW-1:0]         req_wdata,
  input logic [NUM_WIN*DW-1:0] remote_set_i,
  input logic                  rd_valid_o,
  input logic                  irq_o,
  input logic [NUM_WIN*DW-1:0] stat_flat,
  input logic [NUM_WIN*DW-1:0] mask_flat,
  input logic                  ien_q
);
  logic clr0;
  logic oob_wr;
  assign clr0   = req_valid & req_write & (req_addr == {1'b0, {IDX_W{1'b0}}, WR_CLR});
  assign oob_wr = req_valid & req_write & ~req_addr[ADDR_W-1] &
                  (32'(req_addr[OFS_W +: IDX_W]) >= NUM_WIN);

  // R1
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (stat_flat == '0) && (&mask_flat) && !irq_o);

  // R8
  p_clear_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (clr0 && |(req_wdata & remote_set_i[DW-1:0])) |=>
      ((stat_flat[DW-1:0] & $past(req_wdata & remote_set_i[DW-1:0])) == '0));

  // R9
  p_oob_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (oob_wr && remote_set_i == '0) |=> ($stable(stat_flat) && $stable(mask_flat)));

  // R7
  p_irq_gated_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(ien_q));

  // R12
  p_rd_strobe_r12: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rd_valid_o);

  p_rd_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && !req_write) |=> !rd_valid_o);
endmodule

bind cw_mbox_bank cw_mbox_bank_chk #(.NUM_WIN(NUM_WIN)) u_chk (.*);

// File: tb/sim_cw_mbox_bank.sv
module sim_cw_mbox_bank;
  localparam int NW = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           req_valid = 1'b0;
  logic           req_write = 1'b0;
  logic [10:0]    req_addr  = '0;
  logic [31:0]    req_wdata = '0;
  logic [NW*32-1:0] remote_set = '0;
  logic           rd_valid;
  logic [31:0]    rd_data;
  logic           irq;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  cw_mbox_bank #(.NUM_WIN(NW)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .remote_set_i(remote_set),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .irq_o(irq)
  );

  function automatic logic [10:0] wa(int win, int ofs);
    return {1'b0, 7'(win), 3'(ofs)};
  endfunction
  function automatic logic [10:0] ga(int ofs);
    return {1'b1, 7'd0, 3'(ofs)};
  endfunction

  task automatic check(logic [31:0] act, logic [31:0] exp, string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: called and returns at a falling edge
  task automatic bus_wr(logic [10:0] a, logic [31:0] d);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic bus_rd(logic [10:0] a, logic [31:0] exp, string tag);
    req_valid = 1; req_write = 0; req_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic irq_chk(logic exp, string tag);
    @(negedge clk);
    check({31'd0, irq}, {31'd0, exp}, tag);
  endtask

  // monitor: pops one expected word per valid strobe
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R12: unexpected read strobe, actual %h expected none", rd_data);
      end else begin
        check(rd_data, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 / R10 reset state
    check({31'd0, irq}, 32'd0, "R1 irq at reset");
    bus_rd(wa(0, 0), 32'h0, "R1 raw status at reset");
    bus_rd(wa(0, 4), 32'hFFFF_FFFF, "R1 mask at reset");
    bus_rd(ga(1), 32'h0, "R1 enable at reset");
    bus_rd(ga(0), 32'd8, "R10 window count");
    // R2 set, R5 masked view hidden by full mask
    bus_wr(wa(0, 1), 32'h0000_00A5);
    bus_rd(wa(0, 0), 32'h0000_00A5, "R2 raw after set");
    bus_rd(wa(0, 3), 32'h0, "R5 masked view fully masked");
    bus_rd(ga(2), 32'h0, "R6 no pending while masked");
    // R3 clear
    bus_wr(wa(0, 2), 32'h0000_0005);
    bus_rd(wa(0, 0), 32'h0000_00A0, "R3 raw after clear");
    // R4 mask clear
    bus_wr(wa(0, 6), 32'h0000_00F0);
    bus_rd(wa(0, 4), 32'hFFFF_FF0F, "R4 mask after mask clear");
    bus_rd(wa(0, 3), 32'h0000_00A0, "R5 masked view");
    bus_rd(ga(2), 32'h1, "R6 window 0 pending");
    bus_rd(ga(3), 32'h0, "R6 combined word 1 empty");
    check({31'd0, irq}, 32'd0, "R7 irq low while disabled");
    // R7 enable
    bus_wr(ga(1), 32'h1);
    irq_chk(1'b1, "R7 irq after enable");
    bus_rd(ga(1), 32'h1, "R7 enable readback");
    bus_rd(ga(6), 32'h8000_0000, "R11 first pending is 0");
    // second window
    bus_wr(wa(5, 6), 32'hFFFF_FFFF);
    bus_wr(wa(5, 1), 32'h0000_0001);
    bus_rd(ga(2), 32'h21, "R6 windows 0 and 5 pending");
    bus_wr(wa(0, 2), 32'hFFFF_FFFF);
    bus_rd(ga(6), 32'h8000_0005, "R11 first pending is 5");
    bus_rd(ga(2), 32'h20, "R6 window 5 only");
    bus_wr(wa(5, 5), 32'h0000_0001);
    bus_rd(wa(5, 3), 32'h0, "R4 mask set hides bit");
    bus_rd(ga(6), 32'h0, "R11 none pending");
    irq_chk(1'b0, "R7 irq drops with no pending");
    // remote set
    bus_wr(wa(3, 6), 32'h0000_0030);
    remote_set[3*32+4] = 1'b1;
    @(negedge clk);
    remote_set = '0;
    bus_rd(wa(3, 0), 32'h0000_0010, "R2 remote set");
    check({31'd0, irq}, 32'd1, "R7 irq after remote set");
    // R8 clear beats simultaneous set
    remote_set[3*32+4] = 1'b1;
    remote_set[3*32+5] = 1'b1;
    bus_wr(wa(3, 2), 32'h0000_0010);
    remote_set = '0;
    bus_rd(wa(3, 0), 32'h0000_0020, "R8 clear wins over set");
    bus_rd(ga(2), 32'h08, "R8 window 3 still pending");
    // R9 ignored accesses
    bus_wr(wa(8, 1), 32'hFFFF_FFFF);
    bus_wr(wa(9, 6), 32'hFFFF_FFFF);
    bus_wr(wa(127, 1), 32'hFFFF_FFFF);
    bus_rd(wa(8, 0), 32'h0, "R9 out-of-range raw reads zero");
    bus_rd(wa(9, 4), 32'h0, "R9 out-of-range mask reads zero");
    bus_rd(ga(2), 32'h08, "R9 combined unchanged");
    bus_wr(wa(3, 0), 32'h0000_1234);
    bus_wr(wa(3, 3), 32'h0000_1234);
    bus_rd(wa(3, 0), 32'h0000_0020, "R9 read-only offsets ignore writes");
    bus_wr(ga(0), 32'h0000_0055);
    bus_rd(ga(0), 32'd8, "R9 config ignores writes");
    bus_rd(wa(3, 1), 32'h0, "R9 write-only offset reads zero");
    bus_rd(ga(7), 32'h0, "R9 unused global reads zero");
    bus_rd(ga(6), 32'h8000_0003, "R11 first pending is 3");
    // R7 disable
    bus_wr(ga(1), 32'h0);
    irq_chk(1'b0, "R7 irq low after disable");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R12: %0d reads unanswered, expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule